// File: doc/BRIEF.md
# Serial Sector Lock-Bit Engine

This block is the slave-side command logic of a serial memory that owns a small set of volatile per-sector protection bits. A host selects the device with an active-low chip select and clocks a frame in on a serial clock. The frame holds an 8-bit opcode, an address of `ADDR_BITS` bits, and then a data phase. Three opcodes are handled. A write-enable opcode arms a one-shot enable latch. A lock-read opcode streams back the addressed sector's lock byte. A lock-write opcode, when armed, replaces the two lock bits of the addressed sector.

The bus runs one, two or four data lines wide, chosen by a mode select, and every field is sent most significant bit first. The sector is taken from the top `SECTOR_BITS` address bits. Input is sampled on the rising edge of the serial clock. Read data is launched on the falling edge. A write is committed only when chip select rises at exactly the end of its single data byte, so a host that stops early or clocks too far loses the write. An erase-suspend indication from the rest of the memory does not block lock writes.

Top module: `lockreg_spi`

## Requirements
- R1: After reset every sector's lock bits read as 0, the enable latch is clear, and the output enables are all 0.
- R2: Mode select 2'b00 and 2'b11 use one line: input on line 0 and output on line 1. 2'b01 uses lines 1:0 for every phase and 2'b10 uses lines 3:0. In each chunk the higher-numbered line carries the more significant bit, and fields go MSB first.
- R3: The header is 8+ADDR_BITS bits long. With the defaults, its last rising edge is cycle 31 (one line), 15 (two lines) or 7 (four lines), counting from 0. The first read chunk appears on the falling edge that follows that rising edge, and no output is enabled before it.
- R4: A lock read returns the byte {6'b0, lock[1:0]} of sector addr[ADDR_BITS-1 -: SECTOR_BITS]. That byte repeats for as long as chip select stays low.
- R5: Opcode `OP_WREN` (default 8'h06) sets the enable latch when chip select rises right after its 8 bits.
- R6: A lock write (`OP_WRLOCK`, default 8'hE5) made while the enable latch is clear changes no lock bit.
- R7: A lock write stores only bits 1:0 of its data byte.
- R8: A lock write whose chip select rises before the 8th data bit or after it is discarded. The enable latch stays as it was.
- R9: A committed lock write clears the enable latch, and its bits are visible in the next frame.
- R10: A lock write commits normally while `eraseSuspend` is 1.
- R11: An opcode other than the read opcode (`OP_RDLOCK`, default 8'hE8) never enables any output line.
- R12: The output enable is nonzero only in the data phase of a lock read. It is 4'b0010 on one line, 4'b0011 on two lines and 4'b1111 on four lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rstN | input | 1 | Asynchronous active-low reset of lock bits and enable latch |
| csN | input | 1 | Active-low chip select; a rising edge ends the frame |
| sck | input | 1 | Serial clock |
| modeSel | input | 2 | Bus width: 00 one line, 01 two lines, 10 four lines, 11 one line |
| eraseSuspend | input | 1 | Erase-suspend indication from the memory core |
| dqIn | input | 4 | Data lines as seen at the pads |
| dqOut | output | 4 | Data line output values |
| dqOe | output | 4 | Per-line output enable |

## Verification
The bench checks the exact edge where read data starts in each bus width, and that no enable shows earlier. A design with an off-by-one header count would shift the lock byte by a chunk or drive the bus during the address. It sends write frames one bit short and one bit long. A design that commits on any count at or past the data byte would then store bits that should be discarded. It writes a second time without a new enable, and writes with a data byte of all ones. These catch a latch that does not clear and a store of more than two bits. Streamed reads of several bytes, and the reserved mode code, show whether the chunk position wraps properly and whether the lanes are chosen correctly.

// File: rtl/lockreg_pkg.sv
package lockreg_pkg;

  typedef enum logic [1:0] {
    MODE_ONE  = 2'b00,
    MODE_TWO  = 2'b01,
    MODE_FOUR = 2'b10,
    MODE_RSVD = 2'b11
  } busMode_e;

  typedef struct packed {
    logic       shiftHdr;
    logic       shiftData;
    logic       driveRead;
    logic       commitWrite;
    logic [1:0] lanesLog2;
  } lockStrobe_t;

endpackage

// File: rtl/lockreg_ctrl.sv
module lockreg_ctrl
  import lockreg_pkg::*;
#(
  parameter int ADDR_BITS = 24,
  parameter logic [7:0] OP_WREN   = 8'h06,
  parameter logic [7:0] OP_RDLOCK = 8'hE8,
  parameter logic [7:0] OP_WRLOCK = 8'hE5
) (
  input  logic        rstN,
  input  logic        csN,
  input  logic        sck,
  input  logic [1:0]  modeSel,
  input  logic [7:0]  opFull,
  input  logic [7:0]  opLow,
  output lockStrobe_t strb,
  output logic [2:0]  rdPos,
  output logic        welQ
);

  localparam int HDR_BITS = 8 + ADDR_BITS;
  localparam int CNT_MAX  = HDR_BITS + 9;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0] cycCnt;
  logic [CNT_W-1:0] hdrCyc;
  logic [CNT_W-1:0] byteCyc;
  logic [CNT_W-1:0] opCyc;
  logic [CNT_W-1:0] endCyc;
  logic [1:0]       lanesLog2;
  logic             wrenDone;

  always_comb begin
    case (busMode_e'(modeSel))
      MODE_TWO: begin
        lanesLog2 = 2'd1;
        hdrCyc    = CNT_W'(HDR_BITS / 2);
        byteCyc   = CNT_W'(4);
      end
      MODE_FOUR: begin
        lanesLog2 = 2'd2;
        hdrCyc    = CNT_W'(HDR_BITS / 4);
        byteCyc   = CNT_W'(2);
      end
      default: begin
        lanesLog2 = 2'd0;
        hdrCyc    = CNT_W'(HDR_BITS);
        byteCyc   = CNT_W'(8);
      end
    endcase
    opCyc  = byteCyc;
    endCyc = hdrCyc + byteCyc;
  end

  // Rising-edge count inside the frame, saturating past any legal length.
  always_ff @(posedge sck or posedge csN) begin
    if (csN) cycCnt <= '0;
    else if (cycCnt != CNT_W'(CNT_MAX)) cycCnt <= cycCnt + 1'b1;
  end

  // Chunk position inside the repeating read byte.
  always_ff @(posedge sck or posedge csN) begin
    if (csN) rdPos <= '0;
    else if (cycCnt >= hdrCyc) rdPos <= (rdPos == 3'(byteCyc - 1'b1)) ? 3'd0 : rdPos + 3'd1;
  end

  assign wrenDone = (opLow == OP_WREN) && (cycCnt == opCyc);

  always_comb begin
    strb.lanesLog2   = lanesLog2;
    strb.shiftHdr    = cycCnt < hdrCyc;
    strb.shiftData   = (cycCnt >= hdrCyc) && (cycCnt < endCyc);
    strb.driveRead   = (cycCnt >= hdrCyc) && (opFull == OP_RDLOCK);
    strb.commitWrite = welQ && (opFull == OP_WRLOCK) && (cycCnt == endCyc);
  end

  // Enable latch, updated when a frame closes.
  always_ff @(posedge csN or negedge rstN) begin
    if (!rstN) welQ <= 1'b0;
    else if (strb.commitWrite) welQ <= 1'b0;
    else if (wrenDone) welQ <= 1'b1;
  end

  assert_wel_clear_R9: assert property (@(posedge csN) disable iff (!rstN)
    strb.commitWrite |=> !welQ);

  assert_rdpos_range_R4: assert property (@(posedge sck) disable iff (csN || !rstN)
    ({{(CNT_W-3){1'b0}}, rdPos} < byteCyc));

endmodule

// File: rtl/lockreg_dpath.sv
module lockreg_dpath
  import lockreg_pkg::*;
#(
  parameter int ADDR_BITS   = 24,
  parameter int SECTOR_BITS = 3
) (
  input  logic        rstN,
  input  logic        csN,
  input  logic        sck,
  input  logic [3:0]  dqIn,
  input  lockStrobe_t strb,
  input  logic [2:0]  rdPos,
  output logic [7:0]  opFull,
  output logic [7:0]  opLow,
  output logic [3:0]  dqOut,
  output logic [3:0]  dqOe
);

  localparam int HDR_BITS = 8 + ADDR_BITS;
  localparam int SECTORS  = 2 ** SECTOR_BITS;

  logic [HDR_BITS-1:0]    hdr;
  logic [1:0]             dataLow;
  logic [SECTOR_BITS-1:0] sector;
  logic [1:0]             lockBits [SECTORS];
  logic [7:0]             rdByte;
  logic [7:0]             shifted;
  logic [3:0]             shiftAmt;

  // Header and data capture; only the final two data bits are kept.
  always_ff @(posedge sck) begin
    if (strb.shiftHdr) begin
      case (strb.lanesLog2)
        2'd0:    hdr <= {hdr[HDR_BITS-2:0], dqIn[0]};
        2'd1:    hdr <= {hdr[HDR_BITS-3:0], dqIn[1:0]};
        default: hdr <= {hdr[HDR_BITS-5:0], dqIn};
      endcase
    end
    if (strb.shiftData) begin
      if (strb.lanesLog2 == 2'd0) dataLow <= {dataLow[0], dqIn[0]};
      else                        dataLow <= dqIn[1:0];
    end
  end

  assign opFull = hdr[HDR_BITS-1 -: 8];
  assign opLow  = hdr[7:0];
  assign sector = hdr[ADDR_BITS-1 -: SECTOR_BITS];

  for (genvar s = 0; s < SECTORS; s++) begin : g_lock
    always_ff @(posedge csN or negedge rstN) begin
      if (!rstN) lockBits[s] <= 2'b00;
      else if (strb.commitWrite && (sector == SECTOR_BITS'(s))) lockBits[s] <= dataLow;
    end

    assert_lock_hold_R6: assert property (@(posedge csN) disable iff (!rstN)
      !(strb.commitWrite && (sector == SECTOR_BITS'(s))) |=> $stable(lockBits[s]));
  end

  always_comb begin
    rdByte   = {6'b0, lockBits[sector]};
    shiftAmt = {1'b0, rdPos} << strb.lanesLog2;
    shifted  = rdByte << shiftAmt;
  end

  // Launch read chunks on the falling edge.
  always_ff @(negedge sck or posedge csN) begin
    if (csN) begin
      dqOut <= 4'b0;
      dqOe  <= 4'b0;
    end else if (strb.driveRead) begin
      case (strb.lanesLog2)
        2'd0: begin
          dqOut <= {2'b0, shifted[7], 1'b0};
          dqOe  <= 4'b0010;
        end
        2'd1: begin
          dqOut <= {2'b0, shifted[7:6]};
          dqOe  <= 4'b0011;
        end
        default: begin
          dqOut <= shifted[7:4];
          dqOe  <= 4'b1111;
        end
      endcase
    end else begin
      dqOut <= 4'b0;
      dqOe  <= 4'b0;
    end
  end

  assert_oe_quiet_hdr_R12: assert property (@(posedge sck) disable iff (csN || !rstN)
    strb.shiftHdr |-> (dqOe == 4'b0));

endmodule

// File: rtl/lockreg_spi.sv
module lockreg_spi
  import lockreg_pkg::*;
#(
  parameter int ADDR_BITS   = 24,
  parameter int SECTOR_BITS = 3,
  parameter logic [7:0] OP_WREN   = 8'h06,
  parameter logic [7:0] OP_RDLOCK = 8'hE8,
  parameter logic [7:0] OP_WRLOCK = 8'hE5
) (
  input  logic       rstN,
  input  logic       csN,
  input  logic       sck,
  input  logic [1:0] modeSel,
  input  logic       eraseSuspend,
  input  logic [3:0] dqIn,
  output logic [3:0] dqOut,
  output logic [3:0] dqOe
);

  lockStrobe_t strb;
  logic [2:0]  rdPos;
  logic [7:0]  opFull;
  logic [7:0]  opLow;
  logic        welQ;

  lockreg_ctrl #(
    .ADDR_BITS(ADDR_BITS), .OP_WREN(OP_WREN),
    .OP_RDLOCK(OP_RDLOCK), .OP_WRLOCK(OP_WRLOCK)
  ) u_ctrl (
    .rstN(rstN), .csN(csN), .sck(sck), .modeSel(modeSel),
    .opFull(opFull), .opLow(opLow), .strb(strb), .rdPos(rdPos), .welQ(welQ)
  );

  lockreg_dpath #(
    .ADDR_BITS(ADDR_BITS), .SECTOR_BITS(SECTOR_BITS)
  ) u_dpath (
    .rstN(rstN), .csN(csN), .sck(sck), .dqIn(dqIn), .strb(strb), .rdPos(rdPos),
    .opFull(opFull), .opLow(opLow), .dqOut(dqOut), .dqOe(dqOe)
  );

  // A write frame closing under erase suspend still consumes the latch.
  assert_suspend_write_R10: assert property (@(posedge csN) disable iff (!rstN)
    (eraseSuspend && strb.commitWrite) |=> !welQ);

endmodule

// File: tb/lockreg_spi_test.sv
module lockreg_spi_test;

  localparam int CLK_PERIOD = 10;
  localparam int HALF = CLK_PERIOD / 2;
  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_RDLOCK = 8'hE8;
  localparam logic [7:0] OP_WRLOCK = 8'hE5;

  logic       rstN, csN, sck, eraseSuspend;
  logic [1:0] modeSel;
  logic [3:0] dqIn, dqOut, dqOe;

  int testsRun = 0;
  int testsFailed = 0;

  lockreg_spi uut (
    .rstN(rstN), .csN(csN), .sck(sck), .modeSel(modeSel),
    .eraseSuspend(eraseSuspend), .dqIn(dqIn), .dqOut(dqOut), .dqOe(dqOe)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int lanesOf(input logic [1:0] m);
    return (m == 2'b01) ? 2 : (m == 2'b10) ? 4 : 1;
  endfunction

  function automatic logic [3:0] maskOf(input logic [1:0] m);
    return (m == 2'b01) ? 4'b0011 : (m == 2'b10) ? 4'b1111 : 4'b0010;
  endfunction

  function automatic logic [23:0] addrOf(input logic [2:0] sec);
    return {sec, 21'h15A5A};
  endfunction

  task automatic beginFrame(input logic [1:0] m);
    modeSel = m;
    csN = 1'b0;
    #(HALF);
  endtask

  task automatic endFrame;
    #(HALF);
    csN = 1'b1;
    #(CLK_PERIOD);
  endtask

  // Shifts nbits MSB first; counts output-enable activity before the last chunk.
  task automatic sendBits(input logic [63:0] val, input int nbits, output int loudCount);
    int lanes = lanesOf(modeSel);
    loudCount = 0;
    for (int i = nbits; i > 0; i -= lanes) begin
      case (lanes)
        1:       dqIn = {3'b0, val[i-1]};
        2:       dqIn = {2'b0, val[i-1 -: 2]};
        default: dqIn = val[i-1 -: 4];
      endcase
      #(HALF) sck = 1'b1;
      #(HALF) sck = 1'b0;
      #1;
      if (i > lanes && dqOe != 4'b0) loudCount++;
    end
  endtask

  task automatic doWren(input logic [1:0] m);
    int loud;
    beginFrame(m);
    sendBits({56'b0, OP_WREN}, 8, loud);
    endFrame();
  endtask

  task automatic doWrite(input logic [1:0] m, input logic [2:0] sec, input logic [8:0] data, input int nbits);
    int loud;
    beginFrame(m);
    sendBits({32'b0, OP_WRLOCK, addrOf(sec)}, 32, loud);
    sendBits({55'b0, data}, nbits, loud);
    endFrame();
  endtask

  task automatic readCheck(input logic [1:0] m, input logic [2:0] sec, input logic [7:0] exp,
                           input int nbytes, input string tag);
    int loud;
    int lanes;
    logic [7:0] b;
    beginFrame(m);
    lanes = lanesOf(m);
    sendBits({32'b0, OP_RDLOCK, addrOf(sec)}, 32, loud);
    check(loud == 0, {tag, " R3 no enable during header"}, loud, 0);
    check(dqOe == maskOf(m), {tag, " R12 enable mask at first data chunk"}, dqOe, maskOf(m));
    for (int k = 0; k < nbytes; k++) begin
      b = 8'h0;
      for (int c = 0; c < 8 / lanes; c++) begin
        if (k != 0 || c != 0) begin
          #(HALF - 1) sck = 1'b1;
          #(HALF) sck = 1'b0;
          #1;
        end
        case (lanes)
          1:       b = {b[6:0], dqOut[1]};
          2:       b = {b[5:0], dqOut[1:0]};
          default: b = {b[3:0], dqOut};
        endcase
      end
      check(b == exp, {tag, " R4 lock byte"}, b, exp);
    end
    endFrame();
    check(dqOe == 4'b0, {tag, " R12 enable off after frame"}, dqOe, 0);
  endtask

  task automatic testReset;
    check(dqOe == 4'b0, "R1 output enable after reset", dqOe, 0);
    readCheck(2'b00, 3'd0, 8'h00, 1, "R1 sector0 after reset");
    readCheck(2'b00, 3'd6, 8'h00, 1, "R1 sector6 after reset");
  endtask

  task automatic testNoEnable;
    doWrite(2'b00, 3'd5, 9'h0FF, 8);
    readCheck(2'b00, 3'd5, 8'h00, 1, "R6 write without enable");
  endtask

  task automatic testMaskedWrite;
    doWren(2'b00);
    doWrite(2'b00, 3'd5, 9'h0FF, 8);
    readCheck(2'b00, 3'd5, 8'h03, 3, "R7 two bits kept, repeated read");
  endtask

  task automatic testLatchCleared;
    doWrite(2'b00, 3'd5, 9'h000, 8);
    readCheck(2'b00, 3'd5, 8'h03, 1, "R9 latch cleared by prior write");
  endtask

  task automatic testDualSuspend;
    eraseSuspend = 1'b1;
    doWren(2'b01);
    doWrite(2'b01, 3'd2, 9'h0FD, 8);
    eraseSuspend = 1'b0;
    readCheck(2'b01, 3'd2, 8'h01, 2, "R10 R2 dual write under suspend");
  endtask

  task automatic testQuad;
    doWren(2'b10);
    doWrite(2'b10, 3'd7, 9'h0AA, 8);
    readCheck(2'b10, 3'd7, 8'h02, 3, "R2 quad write and read");
    readCheck(2'b10, 3'd5, 8'h03, 1, "R2 quad read other sector");
  endtask

  task automatic testBadLength;
    doWren(2'b00);
    doWrite(2'b00, 3'd1, 9'h001, 7);
    readCheck(2'b00, 3'd1, 8'h00, 1, "R8 short data byte discarded");
    doWrite(2'b00, 3'd1, 9'h007, 9);
    readCheck(2'b00, 3'd1, 8'h00, 1, "R8 long data byte discarded");
    doWrite(2'b00, 3'd1, 9'h002, 8);
    readCheck(2'b00, 3'd1, 8'h02, 1, "R5 R8 latch kept across aborts");
  endtask

  task automatic testUnknownOp;
    int loud;
    int loudTail = 0;
    beginFrame(2'b00);
    sendBits({32'b0, 8'h9F, addrOf(3'd5)}, 32, loud);
    if (dqOe != 4'b0) loudTail++;
    for (int c = 0; c < 16; c++) begin
      dqIn = 4'b0;
      #(HALF - 1) sck = 1'b1;
      #(HALF) sck = 1'b0;
      #1;
      if (dqOe != 4'b0) loudTail++;
    end
    endFrame();
    check(loud + loudTail == 0, "R11 unknown opcode never drives", loud + loudTail, 0);
  endtask

  task automatic testReservedMode;
    readCheck(2'b11, 3'd5, 8'h03, 2, "R2 reserved mode acts as single line");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    rstN = 1'b0; csN = 1'b1; sck = 1'b0; modeSel = 2'b00;
    eraseSuspend = 1'b0; dqIn = 4'b0;
    #(3 * CLK_PERIOD);
    csN = 1'b0; #(HALF); csN = 1'b1; #(HALF);
    rstN = 1'b1;
    #(CLK_PERIOD);
    testReset();
    testNoEnable();
    testMaskedWrite();
    testLatchCleared();
    testDualSuspend();
    testQuad();
    testBadLength();
    testUnknownOp();
    testReservedMode();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule